// File: doc/BRIEF.md
# Pipelined AES Round Unit

This block computes a single AES round on a 128-bit state in one pass through combinational logic, cut by pipeline registers. Each issue carries a state, a round key and a 2-bit operation code that picks one of four round variants: a full encryption round, the final encryption round, a full decryption round, or the final decryption round. All four variants share one datapath. The same substitution and column-mixing hardware serves both directions.

There is no handshake. A new, unrelated round can be issued on every clock by raising `in_valid`. Its result leaves on `out_data` exactly two clocks later, marked by `out_valid`. The operation code and round key travel down the pipeline with their data, so rounds of different kinds can be interleaved freely. S-box values are formed from a GF(2^8) multiplicative inverse plus an affine map, not from a stored table. Key expansion, key-assist helpers and sequencing of several rounds belong to the caller.

Top module: `aesr_round_unit`

## Requirements
- R1: With `in_op` = 2'b00 (full encrypt round), the result is ShiftRows, then SubBytes, then MixColumns, then XOR with `in_key`.
- R2: With `in_op` = 2'b01 (final encrypt round), the result is ShiftRows, then SubBytes, then XOR with `in_key`. MixColumns is skipped.
- R3: With `in_op` = 2'b10 (full decrypt round), the result is inverse ShiftRows, then inverse SubBytes, then inverse MixColumns, then XOR with `in_key`. Chaining a decrypt round with a key passed through inverse MixColumns undoes an encrypt round.
- R4: With `in_op` = 2'b11 (final decrypt round), the result is inverse ShiftRows, then inverse SubBytes, then XOR with `in_key`. Inverse MixColumns is skipped.
- R5: The forward and inverse S-box give the standard AES substitution for all 256 byte values. This includes 0x00 mapping to 0x63, and 0x53 mapping to 0xED.
- R6: The state is column-major. Byte 0 is bits [127:120] and is row 0 of column 0. Bytes 4c..4c+3 form column c, and the row of byte i is i mod 4.
- R7: `out_valid` is high in exactly the cycle two rising edges after the edge that sampled `in_valid` high. `out_data` holds that issue's result in that cycle.
- R8: One independent operation is accepted per clock. Back-to-back issues with mixed operation codes and keys each produce their own correct result, in issue order.
- R9: While `rst_n` is low on a rising edge, every valid flag in the pipeline is cleared. No output is marked valid for anything sampled during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low, clears valid flags |
| in_valid | input | 1 | Issue strobe for this cycle's operation |
| in_op | input | 2 | Round variant: 00 encrypt, 01 final encrypt, 10 decrypt, 11 final decrypt |
| in_state | input | 128 | Input state, byte 0 in bits [127:120] |
| in_key | input | 128 | Round key XORed at the end of the round |
| out_valid | output | 1 | Result valid, two cycles after issue |
| out_data | output | 128 | Round result |

## Verification
The bench drives every one of the 256 byte values through both S-box directions using final rounds. An inverter or affine map with a wrong constant or rotation would corrupt specific bytes there. It places a single marked byte in row 1 to catch a row rotation in the wrong direction or a reversed byte order. These would move the byte to the wrong column or scramble the published single-round vectors. A long stream of back-to-back issues with mixed operation codes exposes an op code or key that drifts out of step with its data, which would apply the wrong variant to the next issue. An encrypt, final-encrypt, decrypt, final-decrypt chain using an inverse-mixed key confirms that the inverse column mix truly inverts the forward one.

// File: rtl/aesr_pkg.sv
// Package: aesr_pkg
// Shared types, sizes and GF(2^8) helpers for the AES round unit.
// Assumes the column-major state layout with byte 0 in the top bits.
package aesr_pkg;

    localparam int BYTE_W  = 8;
    localparam int NROW    = 4;
    localparam int NCOL    = 4;
    localparam int NBYTE   = NROW * NCOL;
    localparam int STATE_W = NBYTE * BYTE_W;
    localparam int COL_W   = NROW * BYTE_W;

    typedef logic [BYTE_W-1:0]  byte_t;
    typedef logic [STATE_W-1:0] state_t;
    typedef logic [COL_W-1:0]   col_t;

    typedef enum logic [1:0] {
        OP_ENC      = 2'b00,
        OP_ENC_LAST = 2'b01,
        OP_DEC      = 2'b10,
        OP_DEC_LAST = 2'b11
    } round_op_e;

    // Multiply by x modulo the AES polynomial.
    function automatic byte_t xtime(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // General GF(2^8) product by shift-and-add.
    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc = '0;
        byte_t sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = xtime(sh);
        end
        return acc;
    endfunction

    // Multiplicative inverse as a^254, mapping zero to zero.
    function automatic byte_t gf_inv(input byte_t a);
        byte_t p = a;
        byte_t r = 8'h01;
        for (int i = 1; i < BYTE_W; i++) begin
            p = gf_mul(p, p);
            r = gf_mul(r, p);
        end
        return r;
    endfunction

    function automatic byte_t rotl8(input byte_t b, input int n);
        return byte_t'((b << n) | (b >> (BYTE_W - n)));
    endfunction

    // Forward affine map applied after inversion.
    function automatic byte_t fwd_affine(input byte_t b);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
    endfunction

    // Inverse affine map applied before inversion.
    function automatic byte_t inv_affine(input byte_t s);
        return rotl8(s, 1) ^ rotl8(s, 3) ^ rotl8(s, 6) ^ 8'h05;
    endfunction

    // Row rotation: row r moves left by r (forward) or right by r (inverse).
    function automatic state_t shift_rows(input state_t s, input logic inverse);
        state_t o;
        int src;
        for (int c = 0; c < NCOL; c++) begin
            for (int r = 0; r < NROW; r++) begin
                src = inverse ? (c - r + NCOL) % NCOL : (c + r) % NCOL;
                o[STATE_W-1-BYTE_W*(r+NROW*c) -: BYTE_W] =
                    s[STATE_W-1-BYTE_W*(r+NROW*src) -: BYTE_W];
            end
        end
        return o;
    endfunction

endpackage

// File: rtl/aesr_sbox_byte.sv
// Module: aesr_sbox_byte
// One S-box lane for either direction. A single GF(2^8) inverter is shared:
// forward = affine(inv(x)), inverse = inv(inv_affine(x)).
// Purely combinational; assumes nothing about its input.
module aesr_sbox_byte
    import aesr_pkg::*;
(
    input  logic  inverse,
    input  byte_t din,
    output byte_t dout
);

    byte_t pre, inv_q;

    // Select the inverter operand by direction.
    always_comb pre = inverse ? inv_affine(din) : din;

    // Shared field inversion.
    always_comb inv_q = gf_inv(pre);

    // Apply the forward affine map only on the encrypt path.
    always_comb dout = inverse ? inv_q : fwd_affine(inv_q);

endmodule

// File: rtl/aesr_sub_layer.sv
// Module: aesr_sub_layer
// Front half of a round: row rotation, then byte substitution over all
// bytes of the state. Direction comes from the operation's decrypt bit.
module aesr_sub_layer
    import aesr_pkg::*;
(
    input  logic   inverse,
    input  state_t din,
    output state_t dout
);

    state_t shifted;

    // Rotate rows in the direction of the operation.
    always_comb shifted = shift_rows(din, inverse);

    // One substitution lane per byte.
    for (genvar i = 0; i < NBYTE; i++) begin : g_lane
        aesr_sbox_byte u_sbox (
            .inverse (inverse),
            .din     (shifted[STATE_W-1-BYTE_W*i -: BYTE_W]),
            .dout    (dout[STATE_W-1-BYTE_W*i -: BYTE_W])
        );
    end

endmodule

// File: rtl/aesr_mix_layer.sv
// Module: aesr_mix_layer
// Back half of a round: forward or inverse column mixing (bypassed for
// final rounds), then XOR with the round key. Combinational.
module aesr_mix_layer
    import aesr_pkg::*;
(
    input  logic   inverse,
    input  logic   skip_mix,
    input  state_t din,
    input  state_t key,
    output state_t dout
);

    // Multiply one column by the circulant matrix of the chosen direction.
    function automatic col_t mix_col(input col_t col, input logic inv);
        byte_t a [NROW];
        byte_t cf[NROW];
        byte_t acc;
        col_t  o;
        cf = inv ? '{8'h0e, 8'h0b, 8'h0d, 8'h09} : '{8'h02, 8'h03, 8'h01, 8'h01};
        for (int r = 0; r < NROW; r++) a[r] = col[COL_W-1-BYTE_W*r -: BYTE_W];
        for (int r = 0; r < NROW; r++) begin
            acc = '0;
            for (int k = 0; k < NROW; k++) acc = acc ^ gf_mul(a[(r+k)%NROW], cf[k]);
            o[COL_W-1-BYTE_W*r -: BYTE_W] = acc;
        end
        return o;
    endfunction

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        col_t mixed;

        // Column mix in the requested direction.
        always_comb mixed = mix_col(din[STATE_W-1-COL_W*c -: COL_W], inverse);

        // Bypass for final rounds, then add the round key.
        always_comb dout[STATE_W-1-COL_W*c -: COL_W] =
            (skip_mix ? din[STATE_W-1-COL_W*c -: COL_W] : mixed) ^
            key[STATE_W-1-COL_W*c -: COL_W];
    end

endmodule

// File: rtl/aesr_round_unit.sv
// Module: aesr_round_unit
// Two-stage pipelined AES round. Stage 1 registers the substituted state
// together with its key and operation. Stage 2 registers the mixed,
// keyed result. Accepts one independent issue per clock. Reset
// (synchronous, active low) clears only the valid flags.
module aesr_round_unit
    import aesr_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [1:0]   in_op,
    input  logic [127:0] in_state,
    input  logic [127:0] in_key,
    output logic         out_valid,
    output logic [127:0] out_data
);

    round_op_e op_in;
    state_t    sub_q;
    state_t    mix_d;

    logic      s1_vld;
    round_op_e s1_op;
    state_t    s1_data;
    state_t    s1_key;

    always_comb op_in = round_op_e'(in_op);

    aesr_sub_layer u_sub (
        .inverse (op_in[1]),
        .din     (in_state),
        .dout    (sub_q)
    );

    // Stage-1 valid flag, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) s1_vld <= 1'b0;
        else        s1_vld <= in_valid;
    end

    // Stage-1 payload: substituted state, key and operation travel together.
    always_ff @(posedge clk) begin
        s1_data <= sub_q;
        s1_key  <= in_key;
        s1_op   <= op_in;
    end

    aesr_mix_layer u_mix (
        .inverse  (s1_op[1]),
        .skip_mix (s1_op[0]),
        .din      (s1_data),
        .key      (s1_key),
        .dout     (mix_d)
    );

    // Output valid flag, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= s1_vld;
    end

    // Output payload register.
    always_ff @(posedge clk) begin
        out_data <= mix_d;
    end

    // R7: an issue reaches stage 1 on the next edge.
    p_issue_enters_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> s1_vld);

    // R9: no stage-1 valid without an issue.
    p_no_phantom_s1_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !s1_vld);

    // R7: stage 1 drains to the output on the following edge.
    p_out_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s1_vld |=> out_valid);

    // R9: no output valid without a stage-1 entry.
    p_no_phantom_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_vld |=> !out_valid);

    // R8: the key moves with its data.
    p_key_travels_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (s1_key == $past(in_key)));

    // R2 and R4: final rounds only add the key to the substituted state.
    p_last_skip_mix_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && s1_op[0]) |=> (out_data == $past(s1_data ^ s1_key)));

endmodule

// File: tb/tb_aesr_round_unit.sv
`timescale 1ns/1ps
// Bench for aesr_round_unit: streaming issues with a reference model built
// from log/antilog tables, plus fixed single-round vectors.
module tb_aesr_round_unit;

    typedef logic [7:0] bt;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [1:0]   in_op;
    logic [127:0] in_state, in_key;
    logic         out_valid;
    logic [127:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    bt alog[256];
    bt lg[256];
    bt sb[256];
    bt isb[256];

    logic [127:0] exp_q[0:2047];
    string        tag_q[0:2047];
    int wr = 0;
    int rd = 0;

    always #2 clk = ~clk;

    aesr_round_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_state(in_state), .in_key(in_key),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bt m_mul(bt x, bt y);
        if (x == 0 || y == 0) return 8'h00;
        return alog[(int'(lg[x]) + int'(lg[y])) % 255];
    endfunction

    function automatic logic [127:0] m_mixall(logic [127:0] s, bit inv);
        bt a[16];
        bt o[16];
        logic [127:0] r;
        for (int i = 0; i < 16; i++) a[i] = s[127-8*i -: 8];
        for (int c = 0; c < 4; c++) begin
            for (int row = 0; row < 4; row++) begin
                if (inv)
                    o[4*c+row] = m_mul(a[4*c+row], 8'h0e) ^ m_mul(a[4*c+(row+1)%4], 8'h0b)
                               ^ m_mul(a[4*c+(row+2)%4], 8'h0d) ^ m_mul(a[4*c+(row+3)%4], 8'h09);
                else
                    o[4*c+row] = m_mul(a[4*c+row], 8'h02) ^ m_mul(a[4*c+(row+1)%4], 8'h03)
                               ^ a[4*c+(row+2)%4] ^ a[4*c+(row+3)%4];
            end
        end
        for (int i = 0; i < 16; i++) r[127-8*i -: 8] = o[i];
        return r;
    endfunction

    // Reference round from the requirements R1..R4 and R6.
    function automatic logic [127:0] m_round(logic [1:0] op, logic [127:0] st, logic [127:0] key);
        bt a[16];
        bt b[16];
        logic [127:0] r;
        int row, col, src;
        for (int i = 0; i < 16; i++) a[i] = st[127-8*i -: 8];
        for (int i = 0; i < 16; i++) begin
            row = i % 4; col = i / 4;
            src = op[1] ? (col + 4 - row) % 4 : (col + row) % 4;
            b[i] = op[1] ? isb[a[row + 4*src]] : sb[a[row + 4*src]];
        end
        for (int i = 0; i < 16; i++) r[127-8*i -: 8] = b[i];
        if (!op[0]) r = m_mixall(r, op[1]);
        return r ^ key;
    endfunction

    task automatic issue(input logic [1:0] op, input logic [127:0] st,
                         input logic [127:0] key, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_state = st; in_key = key;
        exp_q[wr] = m_round(op, st, key);
        tag_q[wr] = tag;
        wr++;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_state = {$urandom, $urandom, $urandom, $urandom};
    endtask

    task automatic run_one(input logic [1:0] op, input logic [127:0] st,
                           input logic [127:0] key, input string tag,
                           output logic [127:0] res);
        issue(op, st, key, tag);
        idle();
        @(negedge clk);
        res = out_data;
    endtask

    // Output monitor: every valid output is matched to the oldest issue.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && out_valid === 1'b1) begin
            if (rd >= wr) begin
                chk(1'b0, "R7 unexpected out_valid", out_data, '0);
            end else begin
                chk(out_data === exp_q[rd], tag_q[rd], out_data, exp_q[rd]);
                rd++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R7 watchdog expired actual=%0d expected=%0d", rd, wr);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] res, x, k1, k2, y1, y, z, xr;
        logic [127:0] st;
        string nm[4];
        nm = '{"R1 enc stream R8", "R2 enc_last stream R8",
               "R3 dec stream R8", "R4 dec_last stream R8"};

        // Reference tables from generator 3.
        alog[0] = 8'h01;
        for (int i = 1; i < 256; i++)
            alog[i] = alog[i-1] ^ {alog[i-1][6:0], 1'b0} ^ (alog[i-1][7] ? 8'h1b : 8'h00);
        lg[0] = 8'h00;
        for (int i = 0; i < 255; i++) lg[alog[i]] = bt'(i);
        for (int v = 0; v < 256; v++) begin
            bt iv, s;
            iv = (v == 0) ? 8'h00 : alog[(255 - int'(lg[v])) % 255];
            for (int j = 0; j < 8; j++)
                s[j] = iv[j] ^ iv[(j+4)%8] ^ iv[(j+5)%8] ^ iv[(j+6)%8] ^ iv[(j+7)%8] ^ ((8'h63 >> j) & 1'b1);
            sb[v] = s;
        end
        for (int v = 0; v < 256; v++) isb[sb[v]] = bt'(v);

        // R9: reset holds valid low even with issues presented.
        rst_n = 1'b0; in_valid = 1'b1; in_op = 2'b00;
        in_state = '1; in_key = '0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(out_valid === 1'b0, "R9 out_valid during reset", {127'b0, out_valid}, '0);
        end
        in_valid = 1'b0; rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(out_valid === 1'b0, "R9 out_valid after reset", {127'b0, out_valid}, '0);

        // R1 and R6: published first-round vector.
        run_one(2'b00, 128'h193de3bea0f4e22b9ac68d2ae9f84808,
                128'ha0fafe1788542cb123a339392a6c7605, "R1 fips round1", res);
        chk(res === 128'ha49c7ff2689f352b6b5bea43026a5049, "R1 R6 fips round1 const",
            res, 128'ha49c7ff2689f352b6b5bea43026a5049);

        // R2: published final-round vector.
        run_one(2'b01, 128'heb40f21e592e38848ba113e71bc342d2,
                128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R2 fips round10", res);
        chk(res === 128'h3925841d02dc09fbdc118597196a0b32, "R2 fips round10 const",
            res, 128'h3925841d02dc09fbdc118597196a0b32);

        // R6: a marked row-1 byte moves one column left (enc) or right (dec).
        run_one(2'b01, 128'h00000000_00530000_00000000_00000000, '0, "R6 mark enc", res);
        chk(res === 128'h63ed6363_63636363_63636363_63636363, "R6 R5 mark enc const",
            res, 128'h63ed6363_63636363_63636363_63636363);
        run_one(2'b11, 128'h00000000_00ed0000_00000000_00000000, '0, "R6 mark dec", res);
        chk(res === 128'h52525252_52525252_52535252_52525252, "R6 R5 mark dec const",
            res, 128'h52525252_52525252_52535252_52525252);

        // R7: exact latency of two edges.
        issue(2'b00, 128'h0123456789abcdef0123456789abcdef, '1, "R7 latency");
        idle();
        chk(out_valid === 1'b0, "R7 valid one edge after issue", {127'b0, out_valid}, '0);
        @(negedge clk);
        chk(out_valid === 1'b1, "R7 valid two edges after issue", {127'b0, out_valid}, 128'd1);
        @(negedge clk);
        chk(out_valid === 1'b0, "R7 valid three edges after issue", {127'b0, out_valid}, '0);

        // R5: all 256 byte values through both S-box directions, back to back.
        for (int t = 0; t < 16; t++) begin
            for (int j = 0; j < 16; j++) st[127-8*j -: 8] = bt'(16*t + j);
            issue(2'b01, st, '0, "R5 sbox sweep fwd");
            issue(2'b11, st, '0, "R5 sbox sweep inv");
            issue(2'b01, st, {$urandom, $urandom, $urandom, $urandom}, "R5 sbox sweep fwd keyed");
        end
        idle();

        // R8: mixed back-to-back stream with occasional bubbles.
        for (int n = 0; n < 400; n++) begin
            logic [1:0] op;
            op = 2'($urandom_range(0, 3));
            issue(op, {$urandom, $urandom, $urandom, $urandom},
                  {$urandom, $urandom, $urandom, $urandom}, nm[op]);
            if (n % 9 == 8) idle();
        end
        idle(); idle(); idle();
        chk(rd == wr, "R8 R7 output count", 128'(rd), 128'(wr));

        // R3: decrypt with inverse-mixed key undoes an encrypt round.
        for (int n = 0; n < 4; n++) begin
            x  = {$urandom, $urandom, $urandom, $urandom};
            k1 = {$urandom, $urandom, $urandom, $urandom};
            k2 = {$urandom, $urandom, $urandom, $urandom};
            run_one(2'b00, x,  k1, "R1 chain enc", y1);
            run_one(2'b01, y1, k2, "R2 chain enc_last", y);
            run_one(2'b10, y ^ k2, m_mixall(k1, 1'b1), "R3 chain dec", z);
            run_one(2'b11, z, '0, "R4 chain dec_last", xr);
            chk(xr === x, "R3 round trip restores state", xr, x);
        end

        // R9: reset mid-stream discards in-flight issues.
        issue(2'b00, '1, '0, "R9 discarded");
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        wr--;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0, "R9 flushed by reset", {127'b0, out_valid}, '0);
        repeat (2) @(negedge clk);
        chk(rd == wr, "R9 no stale output", 128'(rd), 128'(wr));

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule